// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is a single comparator channel of a multi-channel event timer. A shared, free-running 64-bit main counter is fed in from outside, together with a global enable and write strobes for the channel's configuration word and the two 32-bit halves of its comparator register. When the counter reaches the comparator, the channel produces a one-cycle interrupt pulse on one of 32 interrupt lines.

The channel runs in one-shot or periodic mode. In periodic mode each match advances the comparator by a stored period. In a narrow mode only the low 32 bits are compared, and any periodic sum is cut back to 32 bits. A one-shot channel in narrow mode also fires once when the low counter word rolls over. A set-value bit lets software load the comparator directly while the channel is periodic. Without it, comparator-half writes in periodic mode go to the period. The output line comes from a 5-bit route field. A legacy-mapping input overrides the route field for channels 0 and 1.

Top module: `evt_chan`

## Requirements
- R1: After reset the configuration readback is 64'h00000C20_00000030: the capability bits at positions 4 (periodic-capable) and 5 (64-bit-capable) are set, and the upper word holds the allowed-route mask with bits 5, 10 and 11 set. The comparator reads all ones, the period reads 0 and no interrupt line is active.
- R2: In one-shot mode (config bit 3 = 0), a channel armed by a comparator write or by the rise of its effective enable fires exactly once. It fires when the counter minus comparator, read as a signed number, is zero or positive. The pulse appears on irq_o one clock after the edge that sampled that counter value and lasts one cycle.
- R3: In periodic mode (bit 3 = 1) with a nonzero period, each match fires a pulse and adds the period to the comparator in the same clock. This repeats until the comparator is ahead of the counter.
- R4: In 32-bit mode (bit 8 = 1) the match uses only the low 32 bits, and the periodic sum is truncated to 32 bits with the upper half held at zero.
- R5: In 32-bit one-shot mode an armed channel also fires when the low 32 counter bits go from all ones to zero. This pulse does not disarm the comparator match.
- R6: A configuration write with bit 8 set clears the upper 32 bits of both comparator and period.
- R7: A comparator-half write goes to the comparator when the channel is one-shot or the set-value bit (bit 6) is 1. Otherwise it goes to the period, with bit 31 of the written word forced to 0 for the upper half, and also for the lower half in 32-bit mode. Every such write clears the set-value bit.
- R8: The lower-half strobe writes bits 31:0 and the upper-half strobe writes bits 63:32; the other half is kept.
- R9: With legacy mapping active, channel 0 drives line 2 (line 0 when APIC routing is off) and channel 1 drives line 8. Otherwise the line number is the route field in config bits 13:9.
- R10: A pulse is emitted only when both the channel enable (bit 2) and the global enable are 1.
- R11: Only config bits 2, 3, 6, 8 and 13:9 are writable. The level-type bit (bit 1) always reads 0, and the capability bits cannot be changed.
- R12: At most one interrupt line is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_i | input | 64 | Shared main counter value |
| glb_en_i | input | 1 | Global enable for all channels |
| legacy_i | input | 1 | Legacy line mapping select |
| cfg_wr_i | input | 1 | Write strobe for the configuration word |
| cmp_lo_wr_i | input | 1 | Write strobe for comparator/period bits 31:0 |
| cmp_hi_wr_i | input | 1 | Write strobe for comparator/period bits 63:32 |
| wdata_i | input | 32 | Write data for all strobes |
| cfg_o | output | 64 | Configuration readback, capability mask in upper word |
| cmp_o | output | 64 | Comparator readback |
| per_o | output | 64 | Period readback |
| irq_o | output | 32 | One-hot interrupt pulse lines |

## Verification
A wrong arming flag shows up as a missing pulse, or as a repeated one, on the cycle after the counter reaches the comparator. A wrongly advanced comparator shows up on cmp_o right after the first periodic match, and as a pulse at the wrong counter value one period later. Wrong write routing or masking shows up on the readback ports right after the write strobe. A bad 32-bit wrap detector only shows at the single counter step from 32'hFFFFFFFF to 0, so that step is driven on purpose.

// File: rtl/evt_chan_pkg.sv
// Shared constants and types for the event timer comparator channel.
// Assumes a fixed layout of the configuration word: the bit positions below
// are decoded by software and must not move.
package evt_chan_pkg;

    localparam int CFG_LVL_B   = 1;   // level-type request, not supported
    localparam int CFG_EN_B    = 2;   // channel enable
    localparam int CFG_PER_B   = 3;   // periodic mode
    localparam int CFG_PCAP_B  = 4;   // periodic-capable (read only)
    localparam int CFG_WCAP_B  = 5;   // 64-bit-capable (read only)
    localparam int CFG_SETV_B  = 6;   // set-value escape
    localparam int CFG_M32_B   = 8;   // 32-bit mode
    localparam int CFG_RTE_LSB = 9;   // route field low bit
    localparam int RTE_W       = 5;   // route field width
    localparam int NLINES      = 1 << RTE_W;

    // Decoded configuration fields.
    typedef struct packed {
        logic             en;
        logic             periodic;
        logic             setval;
        logic             mode32;
        logic [RTE_W-1:0] route;
    } chan_cfg_t;

endpackage

// File: rtl/evt_chan_cfg.sv
// Configuration register of one channel.
// Holds only the writable bits; capability bits and the allowed-route mask
// are constants merged into the readback. Assumes at most one write strobe
// per cycle.
module evt_chan_cfg
    import evt_chan_pkg::*;
#(
    parameter int                WORD_W    = 32,
    parameter logic [WORD_W-1:0] ROUTE_CAP = 32'h0000_0C20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic                cmp_wr,
    input  logic [WORD_W-1:0]   wdata,
    output chan_cfg_t           cfg,
    output logic [2*WORD_W-1:0] cfg_rd
);

    localparam logic [WORD_W-1:0] WR_MASK =
        WORD_W'((32'h1 << CFG_EN_B) | (32'h1 << CFG_PER_B) |
                (32'h1 << CFG_SETV_B) | (32'h1 << CFG_M32_B) |
                (((32'h1 << RTE_W) - 32'h1) << CFG_RTE_LSB));
    localparam logic [WORD_W-1:0] CAP_BITS =
        WORD_W'((32'h1 << CFG_PCAP_B) | (32'h1 << CFG_WCAP_B));

    logic [WORD_W-1:0] cfg_q;

    // Store writable bits; a comparator write drops the set-value bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_wr) begin
            cfg_q <= wdata & WR_MASK;
        end else if (cmp_wr) begin
            cfg_q[CFG_SETV_B] <= 1'b0;
        end
    end

    // Decode fields and build the readback word.
    always_comb begin
        cfg.en       = cfg_q[CFG_EN_B];
        cfg.periodic = cfg_q[CFG_PER_B];
        cfg.setval   = cfg_q[CFG_SETV_B];
        cfg.mode32   = cfg_q[CFG_M32_B];
        cfg.route    = cfg_q[CFG_RTE_LSB +: RTE_W];
        cfg_rd       = {ROUTE_CAP, cfg_q | CAP_BITS};
    end

endmodule

// File: rtl/evt_chan_cmp.sv
// Comparator and period registers of one channel.
// Steers half-word writes to comparator or period, truncates both when the
// 32-bit mode is written, and applies the periodic advance. Software writes
// take priority over the advance in the same cycle.
module evt_chan_cmp #(
    parameter int WORD_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                periodic,
    input  logic                setval,
    input  logic                mode32,
    input  logic                trunc_wr,
    input  logic                lo_wr,
    input  logic                hi_wr,
    input  logic [WORD_W-1:0]   wdata,
    input  logic                advance,
    output logic [2*WORD_W-1:0] cmp,
    output logic [2*WORD_W-1:0] per
);

    localparam int CNT_W = 2 * WORD_W;

    logic                to_cmp;
    logic [WORD_W-1:0]   wdata_clip;
    logic [WORD_W-1:0]   per_lo_wd;
    logic [WORD_W-1:0]   sum_lo;
    logic [CNT_W-1:0]    cmp_next;

    // Pick the target of a half write and the masked period data.
    always_comb begin
        to_cmp     = !periodic || setval;
        wdata_clip = {1'b0, wdata[WORD_W-2:0]};
        per_lo_wd  = mode32 ? wdata_clip : wdata;
        sum_lo     = cmp[WORD_W-1:0] + per[WORD_W-1:0];
        cmp_next   = mode32 ? {{WORD_W{1'b0}}, sum_lo} : (cmp + per);
    end

    // Update comparator and period from writes, truncation or advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp <= '1;
            per <= '0;
        end else if (trunc_wr) begin
            cmp[CNT_W-1:WORD_W] <= '0;
            per[CNT_W-1:WORD_W] <= '0;
        end else if (lo_wr) begin
            if (to_cmp) begin
                cmp[WORD_W-1:0] <= wdata;
            end else begin
                per[WORD_W-1:0] <= per_lo_wd;
            end
        end else if (hi_wr) begin
            if (to_cmp) begin
                cmp[CNT_W-1:WORD_W] <= wdata;
            end else begin
                per[CNT_W-1:WORD_W] <= wdata_clip;
            end
        end else if (advance) begin
            cmp <= cmp_next;
        end
    end

endmodule

// File: rtl/evt_chan_fire.sv
// Match and wrap detection of one channel.
// A match is a signed difference of counter minus comparator that is not
// negative, taken over 32 or 64 bits. One-shot channels fire once per arming;
// periodic channels fire on every match and request an advance. Assumes the
// counter is sampled every cycle so that a wrap step is seen.
module evt_chan_fire #(
    parameter int WORD_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*WORD_W-1:0] cnt,
    input  logic [2*WORD_W-1:0] cmp,
    input  logic [2*WORD_W-1:0] per,
    input  logic                en,
    input  logic                periodic,
    input  logic                mode32,
    input  logic                glb_en,
    input  logic                cmp_wr,
    output logic                fire,
    output logic                advance
);

    localparam int CNT_W = 2 * WORD_W;

    logic              armed;
    logic              active_q;
    logic [WORD_W-1:0] prev_lo;
    logic              prev_vld;

    logic              active;
    logic              act_rise;
    logic [CNT_W-1:0]  diff;
    logic              reached;
    logic              per_mode;
    logic              match_fire;
    logic              wrap_ev;

    // Evaluate match, wrap and the resulting fire decision.
    always_comb begin
        active     = glb_en && en;
        act_rise   = active && !active_q;
        diff       = cnt - cmp;
        reached    = mode32 ? !diff[WORD_W-1] : !diff[CNT_W-1];
        per_mode   = periodic && (per != '0);
        match_fire = active && armed && reached && !cmp_wr;
        wrap_ev    = active && armed && mode32 && !periodic && !cmp_wr &&
                     prev_vld && (prev_lo == '1) && (cnt[WORD_W-1:0] == '0);
        fire       = match_fire || wrap_ev;
        advance    = match_fire && per_mode;
    end

    // Arming state: set by writes, cleared by a one-shot match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (cmp_wr) begin
            armed <= 1'b1;
        end else if (match_fire && !per_mode) begin
            armed <= 1'b0;
        end else if (act_rise) begin
            armed <= 1'b1;
        end
    end

    // History of enable and low counter word for edge and wrap detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            prev_lo  <= '0;
            prev_vld <= 1'b0;
        end else begin
            active_q <= active;
            prev_lo  <= cnt[WORD_W-1:0];
            prev_vld <= 1'b1;
        end
    end

endmodule

// File: rtl/evt_chan_route.sv
// Interrupt line selection and output register of one channel.
// Legacy mapping overrides the route field for channels 0 and 1 only.
// Produces a registered one-hot pulse, one bit per line.
module evt_chan_route #(
    parameter int RTE_W      = 5,
    parameter int CHAN_ID    = 0,
    parameter bit APIC_ROUTE = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                legacy,
    input  logic [RTE_W-1:0]    route,
    input  logic                fire,
    output logic [(1<<RTE_W)-1:0] irq
);

    localparam int          NL   = 1 << RTE_W;
    localparam logic [RTE_W-1:0] LEG0 = APIC_ROUTE ? RTE_W'(2) : RTE_W'(0);
    localparam logic [RTE_W-1:0] LEG1 = RTE_W'(8);

    logic [RTE_W-1:0] line;

    // Choose the target line from legacy mapping or the route field.
    always_comb begin
        if (legacy && (CHAN_ID == 0)) begin
            line = LEG0;
        end else if (legacy && (CHAN_ID == 1)) begin
            line = LEG1;
        end else begin
            line = route;
        end
    end

    for (genvar gi = 0; gi < NL; gi++) begin : g_line
        // Register the pulse for this line.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                irq[gi] <= 1'b0;
            end else begin
                irq[gi] <= fire && (line == RTE_W'(gi));
            end
        end
    end

endmodule

// File: rtl/evt_chan.sv
// Top of one event timer comparator channel.
// Ties together the configuration, comparator, detection and routing parts.
// Assumes the caller issues at most one write strobe per cycle and writes the
// upper comparator half before the lower one when arming a 64-bit match.
module evt_chan
    import evt_chan_pkg::*;
#(
    parameter int                WORD_W     = 32,
    parameter int                CHAN_ID    = 0,
    parameter bit                APIC_ROUTE = 1'b1,
    parameter logic [WORD_W-1:0] ROUTE_CAP  = 32'h0000_0C20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*WORD_W-1:0] cnt_i,
    input  logic                glb_en_i,
    input  logic                legacy_i,
    input  logic                cfg_wr_i,
    input  logic                cmp_lo_wr_i,
    input  logic                cmp_hi_wr_i,
    input  logic [WORD_W-1:0]   wdata_i,
    output logic [2*WORD_W-1:0] cfg_o,
    output logic [2*WORD_W-1:0] cmp_o,
    output logic [2*WORD_W-1:0] per_o,
    output logic [NLINES-1:0]   irq_o
);

    chan_cfg_t cfg;
    logic      cmp_wr;
    logic      trunc_wr;
    logic      chan_fire;
    logic      chan_adv;

    // Combine strobes used by more than one part.
    always_comb begin
        cmp_wr   = cmp_lo_wr_i || cmp_hi_wr_i;
        trunc_wr = cfg_wr_i && wdata_i[CFG_M32_B];
    end

    evt_chan_cfg #(
        .WORD_W    (WORD_W),
        .ROUTE_CAP (ROUTE_CAP)
    ) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_wr (cfg_wr_i),
        .cmp_wr (cmp_wr),
        .wdata  (wdata_i),
        .cfg    (cfg),
        .cfg_rd (cfg_o)
    );

    evt_chan_cmp #(
        .WORD_W (WORD_W)
    ) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .periodic (cfg.periodic),
        .setval   (cfg.setval),
        .mode32   (cfg.mode32),
        .trunc_wr (trunc_wr),
        .lo_wr    (cmp_lo_wr_i),
        .hi_wr    (cmp_hi_wr_i),
        .wdata    (wdata_i),
        .advance  (chan_adv),
        .cmp      (cmp_o),
        .per      (per_o)
    );

    evt_chan_fire #(
        .WORD_W (WORD_W)
    ) u_fire (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt      (cnt_i),
        .cmp      (cmp_o),
        .per      (per_o),
        .en       (cfg.en),
        .periodic (cfg.periodic),
        .mode32   (cfg.mode32),
        .glb_en   (glb_en_i),
        .cmp_wr   (cmp_wr),
        .fire     (chan_fire),
        .advance  (chan_adv)
    );

    evt_chan_route #(
        .RTE_W      (RTE_W),
        .CHAN_ID    (CHAN_ID),
        .APIC_ROUTE (APIC_ROUTE)
    ) u_route (
        .clk    (clk),
        .rst_n  (rst_n),
        .legacy (legacy_i),
        .route  (cfg.route),
        .fire   (chan_fire),
        .irq    (irq_o)
    );

endmodule

// File: rtl/evt_chan_chk.sv
// Property checker for the event timer channel, bound to every instance.
// Observes ports and the internal fire strobe; drives nothing.
module evt_chan_chk
    import evt_chan_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                glb_en_i,
    input logic                cfg_wr_i,
    input logic                cmp_lo_wr_i,
    input logic                cmp_hi_wr_i,
    input logic [2*WORD_W-1:0] cfg_o,
    input logic [2*WORD_W-1:0] cmp_o,
    input logic [2*WORD_W-1:0] per_o,
    input logic [NLINES-1:0]   irq_o,
    input logic                chan_fire
);

    // R12
    one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_o));

    // R10
    gated_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o != '0) |-> ($past(glb_en_i) && $past(cfg_o[CFG_EN_B])));

    // R3
    periodic_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_fire && cfg_o[CFG_PER_B] && !cfg_o[CFG_M32_B] && (per_o != '0) &&
         !cfg_wr_i && !cmp_lo_wr_i && !cmp_hi_wr_i)
        |=> (cmp_o == $past(cmp_o) + $past(per_o)));

    // R7
    setval_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmp_lo_wr_i || cmp_hi_wr_i) && !cfg_wr_i) |=> !cfg_o[CFG_SETV_B]);

    // R2
    single_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_o != '0) && !cfg_o[CFG_PER_B] && !cfg_o[CFG_M32_B] &&
         !$past(cfg_wr_i) && !cfg_wr_i && !cmp_lo_wr_i && !cmp_hi_wr_i)
        |=> (irq_o == '0));

endmodule

bind evt_chan evt_chan_chk #(
    .WORD_W (WORD_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .glb_en_i    (glb_en_i),
    .cfg_wr_i    (cfg_wr_i),
    .cmp_lo_wr_i (cmp_lo_wr_i),
    .cmp_hi_wr_i (cmp_hi_wr_i),
    .cfg_o       (cfg_o),
    .cmp_o       (cmp_o),
    .per_o       (per_o),
    .irq_o       (irq_o),
    .chan_fire   (chan_fire)
);

// File: tb/evt_chan_tb.sv
// Self-checking bench for evt_chan: register write table, then timed tests.
module evt_chan_tb;

    localparam int CLK_P = 10;
    localparam int NV    = 13;

    // Write table: op 0 = config, 1 = lower half, 2 = upper half.
    localparam logic [1:0]  T_OP  [NV] = '{2, 1, 0, 1, 2, 0, 1, 1, 0, 1, 0, 0, 0};
    localparam logic [31:0] T_DAT [NV] = '{
        32'h12, 32'h34, 32'h8, 32'h8000_0005, 32'hFFFF_FFFF, 32'h48, 32'h56,
        32'h7, 32'h108, 32'hFFFF_FFFF, 32'h10A, 32'hFFFF_FFFF, 32'h0};
    localparam logic [31:0] T_CFG [NV] = '{
        32'h30, 32'h30, 32'h38, 32'h38, 32'h38, 32'h78, 32'h38,
        32'h38, 32'h138, 32'h138, 32'h138, 32'h3F7C, 32'h30};
    localparam logic [63:0] T_CMP [NV] = '{
        64'h12_FFFF_FFFF, 64'h12_0000_0034, 64'h12_0000_0034, 64'h12_0000_0034,
        64'h12_0000_0034, 64'h12_0000_0034, 64'h12_0000_0056, 64'h12_0000_0056,
        64'h56, 64'h56, 64'h56, 64'h56, 64'h56};
    localparam logic [63:0] T_PER [NV] = '{
        64'h0, 64'h0, 64'h0, 64'h8000_0005, 64'h7FFF_FFFF_8000_0005,
        64'h7FFF_FFFF_8000_0005, 64'h7FFF_FFFF_8000_0005, 64'h7FFF_FFFF_0000_0007,
        64'h7, 64'h7FFF_FFFF, 64'h7FFF_FFFF, 64'h7FFF_FFFF, 64'h7FFF_FFFF};
    localparam string   T_REQ [NV] = '{
        "R8", "R8", "R11", "R7", "R7", "R11", "R7", "R8", "R6", "R7", "R11", "R11", "R11"};

    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] cnt_i;
    logic        glb_en_i, legacy_i, cfg_wr_i, cmp_lo_wr_i, cmp_hi_wr_i;
    logic [31:0] wdata_i;
    logic [63:0] cfg_o, cmp_o, per_o;
    logic [31:0] irq_o;

    int checks = 0;
    int errors = 0;

    evt_chan u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt_i       (cnt_i),
        .glb_en_i    (glb_en_i),
        .legacy_i    (legacy_i),
        .cfg_wr_i    (cfg_wr_i),
        .cmp_lo_wr_i (cmp_lo_wr_i),
        .cmp_hi_wr_i (cmp_hi_wr_i),
        .wdata_i     (wdata_i),
        .cfg_o       (cfg_o),
        .cmp_o       (cmp_o),
        .per_o       (per_o),
        .irq_o       (irq_o)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock: inputs already set at a falling edge; returns at the next one.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] op, input logic [31:0] d);
        wdata_i     = d;
        cfg_wr_i    = (op == 2'd0);
        cmp_lo_wr_i = (op == 2'd1);
        cmp_hi_wr_i = (op == 2'd2);
        tick();
        cfg_wr_i    = 1'b0;
        cmp_lo_wr_i = 1'b0;
        cmp_hi_wr_i = 1'b0;
    endtask

    task automatic do_reset();
        rst_n    = 1'b0;
        glb_en_i = 1'b0;
        legacy_i = 1'b0;
        cnt_i    = '0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    task automatic step_cnt(input logic [63:0] c, input string req, input logic [31:0] exp_irq);
        cnt_i = c;
        tick();
        chk(req, {32'h0, irq_o}, {32'h0, exp_irq});
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cfg_wr_i = 1'b0; cmp_lo_wr_i = 1'b0; cmp_hi_wr_i = 1'b0; wdata_i = '0;
        @(negedge clk);
        do_reset();

        // R1 reset state
        chk("R1", cfg_o, 64'h0000_0C20_0000_0030);
        chk("R1", cmp_o, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R1", per_o, 64'h0);
        chk("R1", {32'h0, irq_o}, 64'h0);

        // Register write table with the global enable off.
        for (int i = 0; i < NV; i++) begin
            wr(T_OP[i], T_DAT[i]);
            chk(T_REQ[i], cfg_o, {32'h0000_0C20, T_CFG[i]});
            chk(T_REQ[i], cmp_o, T_CMP[i]);
            chk(T_REQ[i], per_o, T_PER[i]);
        end

        // R2 one-shot on route 5
        do_reset();
        wr(2'd0, 32'hA04);
        wr(2'd2, 32'h0);
        wr(2'd1, 32'd100);
        glb_en_i = 1'b1;
        step_cnt(64'd98,  "R2", 32'h0);
        step_cnt(64'd100, "R2", 32'h20);
        step_cnt(64'd101, "R2", 32'h0);
        step_cnt(64'd150, "R2", 32'h0);

        // R10 gating by global and channel enable
        wr(2'd1, 32'd300);
        glb_en_i = 1'b0;
        step_cnt(64'd300, "R10", 32'h0);
        step_cnt(64'd301, "R10", 32'h0);
        wr(2'd0, 32'hA00);
        glb_en_i = 1'b1;
        step_cnt(64'd302, "R10", 32'h0);

        // R9 legacy mapping sends channel 0 to line 2
        legacy_i = 1'b1;
        wr(2'd0, 32'hA04);
        wr(2'd1, 32'd400);
        step_cnt(64'd399, "R9", 32'h0);
        step_cnt(64'd400, "R9", 32'h4);
        legacy_i = 1'b0;

        // R3 periodic on route 3 with period 50
        do_reset();
        wr(2'd0, 32'h64C);
        wr(2'd2, 32'h0);
        wr(2'd0, 32'h64C);
        wr(2'd1, 32'd200);
        wr(2'd1, 32'd50);
        chk("R7", per_o, 64'd50);
        glb_en_i = 1'b1;
        step_cnt(64'd199, "R3", 32'h0);
        step_cnt(64'd200, "R3", 32'h8);
        chk("R3", cmp_o, 64'd250);
        step_cnt(64'd201, "R3", 32'h0);
        step_cnt(64'd250, "R3", 32'h8);
        chk("R3", cmp_o, 64'd300);

        // R5 wrap pulse in 32-bit one-shot mode, then the match
        do_reset();
        wr(2'd0, 32'hB04);
        cnt_i = 64'hFFFF_FFFE;
        wr(2'd1, 32'h10);
        chk("R6", cmp_o, 64'h10);
        glb_en_i = 1'b1;
        step_cnt(64'hFFFF_FFFE,   "R5", 32'h0);
        step_cnt(64'hFFFF_FFFF,   "R5", 32'h0);
        step_cnt(64'h1_0000_0000, "R5", 32'h20);
        step_cnt(64'h1_0000_0005, "R4", 32'h0);
        step_cnt(64'h1_0000_0010, "R4", 32'h20);
        step_cnt(64'h1_0000_0011, "R4", 32'h0);

        // R4 32-bit periodic sum wraps to the low word
        do_reset();
        wr(2'd0, 32'h14C);
        wr(2'd1, 32'hFFFF_FFF0);
        wr(2'd1, 32'h20);
        cnt_i = 64'hFFFF_FFF0;
        glb_en_i = 1'b1;
        step_cnt(64'hFFFF_FFF0, "R4", 32'h1);
        chk("R4", cmp_o, 64'h10);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule